// File: doc/BRIEF.md
# Cascadable I2C Segment Register Loader

This block is a receive-only I2C slave that fills the segment data registers of a display driver. Several identical copies can share one bus and one fixed 7-bit address. Each copy is told apart by a hardwired 3-bit chip-select code. SCL and SDA come in as plain inputs that the system clock oversamples. The block pulls SDA low through a single output enable, which the board turns into an open-drain driver.

A transfer has three parts:
- A start condition, then the address byte. Every copy on the bus answers the address at the same time.
- A control byte. Every addressed copy stores it and acknowledges it.
- Any number of data bytes. Each data byte lands at the position named by a 6-bit byte vector. The vector is loaded from the control byte and steps by one after each data byte. Its top three bits choose which copy owns the byte, and only that copy stores the byte and acknowledges it.

Every copy advances its own copy of the vector, whether or not it owns the byte. When the vector wraps from 63 to 0, the write stream passes on to the copy whose code matches the new upper bits. A stop that comes right after the control byte changes only the control register.

Top module: `seg_loader_i2c`

## Requirements
- R1: After an asynchronous reset, all eight segment bytes and the control register read zero, and `sda_oe_o` is 0.
- R2: The first byte after a start is acknowledged only when it equals 0x74, which is address 0111010 followed by write bit 0. The acknowledge comes whatever the value of `cs_i`. Any other value, including a read bit of 1, gets no acknowledge.
- R3: After a matching address, the next byte is acknowledged and stored in `ctrl_o`. Bits [5:0] of this byte become the starting byte vector, bit 6 is the bank bit, and bit 7 is kept but has no effect.
- R4: A data byte is acknowledged and stored when byte vector bits [5:3] equal `cs_i`. It goes into segment byte k = vector bits [2:0], which appears on `seg_o[8k+7:8k]`. The vector then steps by one.
- R5: A data byte whose vector bits [5:3] differ from `cs_i` gets no acknowledge and changes no segment byte. The vector still steps by one.
- R6: The byte vector wraps from 63 to 0 within one transfer. Ownership is decided again for every byte, so the device with `cs_i` = 0 takes the stream over after the wrap.
- R7: A stop right after the control byte acknowledge leaves every segment byte unchanged and updates only `ctrl_o`.
- R8: After a non-matching address, the device acknowledges and stores nothing until the next start. A repeated start restarts address matching.
- R9: `sda_oe_o` is high only during the acknowledge clock of a byte. It rises while SCL is low and is low after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (the resolved bus) |
| cs_i | input | 3 | Hardwired chip-select code, compared with vector bits [5:3] |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| seg_o | output | 64 | Eight segment bytes; byte k sits at [8k+7:8k] |
| ctrl_o | output | 8 | Control register |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, address 0111010, a 3-bit chip select and eight segment bytes. This full 6-bit vector space makes several cases reachable:
- a window that straddles the boundary between two chip-select codes;
- a wrap from 63 to 0 that hands ownership to code 0;
- a stop placed directly after the control byte.

Changing `cs_i` between transfers lets one instance play both an owning device and a non-owning device. The bench also drives a read-bit address, a foreign address and a repeated start after a rejected address, and watches the acknowledge line and the registers after each.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_SKIP
  } seg_st_e;
endpackage

// File: rtl/segld_line_sync.sv
module segld_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic scl_q, sda_q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
          end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
          end else begin
            scl_q <= g_stage[g-1].scl_q;
            sda_q <= g_stage[g-1].sda_q;
          end
        end
      end
    end
  endgenerate

  logic scl_d, sda_d;
  assign scl_o = g_stage[STAGES-1].scl_q;
  assign sda_o = g_stage[STAGES-1].sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_o;
      sda_d <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edges while SCL stays high are bus conditions
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/segld_frame_ctl.sv
module segld_frame_ctl
  import segld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111010,
  parameter int         CS_W     = 3,
  parameter int         IDX_W    = 3,
  localparam int        VEC_W    = CS_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [CS_W-1:0]   cs_i,
  output logic              sda_oe_o,
  output logic              ctrl_we_o,
  output logic              seg_we_o,
  output logic [IDX_W-1:0]  seg_idx_o,
  output logic [BYTE_W-1:0] byte_o,
  output seg_st_e           st_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [3:0]        bit_cnt_o,
  output logic              byte_done_o
);
  localparam logic [3:0] CNT_ACK  = 4'd8;
  localparam logic [3:0] CNT_HOLD = 4'd9;

  seg_st_e           st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [VEC_W-1:0]  vec;
  logic              oe;
  logic              addr_ok, owner, byte_done;

  assign addr_ok   = (shreg == {DEV_ADDR, 1'b0});
  assign owner     = (vec[VEC_W-1 -: CS_W] == cs_i);
  // the eighth bit has been shifted in; SCL now falls into the acknowledge clock
  assign byte_done = scl_fall_i && (bit_cnt == CNT_ACK) && (st != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      vec     <= '0;
      oe      <= 1'b0;
    end else if (start_i) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      oe      <= 1'b0;
    end else if (stop_i) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      oe      <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise_i && bit_cnt < CNT_ACK) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_i};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (byte_done) begin
        bit_cnt <= CNT_HOLD;
        unique case (st)
          ST_ADDR: begin
            oe <= addr_ok;
            st <= addr_ok ? ST_CTRL : ST_SKIP;
          end
          ST_CTRL: begin
            oe  <= 1'b1;
            vec <= shreg[VEC_W-1:0];
            st  <= ST_DATA;
          end
          ST_DATA: begin
            oe  <= owner;
            vec <= vec + 1'b1;
          end
          default: oe <= 1'b0;
        endcase
      end else if (scl_fall_i && bit_cnt == CNT_HOLD) begin
        bit_cnt <= '0;
        oe      <= 1'b0;
      end
    end
  end

  assign sda_oe_o    = oe;
  assign ctrl_we_o   = byte_done && (st == ST_CTRL);
  assign seg_we_o    = byte_done && (st == ST_DATA) && owner;
  assign seg_idx_o   = vec[IDX_W-1:0];
  assign byte_o      = shreg;
  assign st_o        = st;
  assign vec_o       = vec;
  assign bit_cnt_o   = bit_cnt;
  assign byte_done_o = byte_done;
endmodule

// File: rtl/segld_seg_bank.sv
module segld_seg_bank
  import segld_pkg::*;
#(
  parameter  int IDX_W   = 3,
  localparam int N_BYTES = 1 << IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      seg_we_i,
  input  logic [IDX_W-1:0]          seg_idx_i,
  input  logic                      ctrl_we_i,
  input  logic [BYTE_W-1:0]         din_i,
  output logic [N_BYTES*BYTE_W-1:0] seg_o,
  output logic [BYTE_W-1:0]         ctrl_o
);
  genvar k;
  generate
    for (k = 0; k < N_BYTES; k++) begin : g_byte
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (seg_we_i && seg_idx_i == IDX_W'(k)) q <= din_i;
      end
      assign seg_o[k*BYTE_W +: BYTE_W] = q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (ctrl_we_i) ctrl_o <= din_i;
  end
endmodule

// File: rtl/seg_loader_i2c.sv
module seg_loader_i2c
  import segld_pkg::*;
#(
  parameter  int         SYNC_STAGES = 2,
  parameter  logic [6:0] DEV_ADDR    = 7'b0111010,
  parameter  int         CS_W        = 3,
  parameter  int         IDX_W       = 3,
  localparam int         VEC_W       = CS_W + IDX_W,
  localparam int         N_BYTES     = 1 << IDX_W,
  localparam int         SEG_W       = N_BYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [CS_W-1:0]   cs_i,
  output logic              sda_oe_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [BYTE_W-1:0] ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ctrl_we, seg_we, byte_done;
  logic [IDX_W-1:0]  seg_idx;
  logic [BYTE_W-1:0] rx_byte;
  logic [VEC_W-1:0]  vec;
  logic [3:0]        bit_cnt;
  seg_st_e           st;

  segld_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  segld_frame_ctl #(.DEV_ADDR(DEV_ADDR), .CS_W(CS_W), .IDX_W(IDX_W)) u_ctl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_i(sda_s), .cs_i,
    .sda_oe_o,
    .ctrl_we_o(ctrl_we), .seg_we_o(seg_we), .seg_idx_o(seg_idx),
    .byte_o(rx_byte), .st_o(st), .vec_o(vec), .bit_cnt_o(bit_cnt),
    .byte_done_o(byte_done)
  );

  segld_seg_bank #(.IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .seg_we_i(seg_we), .seg_idx_i(seg_idx), .ctrl_we_i(ctrl_we),
    .din_i(rx_byte), .seg_o, .ctrl_o
  );
endmodule

// File: rtl/segld_chk.sv
module segld_chk
  import segld_pkg::*;
#(
  parameter int CS_W  = 3,
  parameter int VEC_W = 6,
  parameter int SEG_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sda_oe_o,
  input logic [CS_W-1:0]   cs_i,
  input logic [SEG_W-1:0]  seg_o,
  input logic [BYTE_W-1:0] ctrl_o,
  input logic              scl_s,
  input logic              stop_det,
  input logic              byte_done,
  input seg_st_e           st,
  input logic [VEC_W-1:0]  vec,
  input logic [3:0]        bit_cnt
);
  a_r9_oe_in_ack_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (bit_cnt == 4'd9));

  a_r9_oe_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  a_r9_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r6_vec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && st == ST_DATA && vec == {VEC_W{1'b1}}) |=> (vec == '0));

  a_r5_unowned_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && st == ST_DATA && vec[VEC_W-1 -: CS_W] != cs_i) |=> $stable(seg_o));

  a_r7_seg_change_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_o) |-> $past(st == ST_DATA));

  a_r3_ctrl_change_in_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(st == ST_CTRL));
endmodule

bind seg_loader_i2c segld_chk #(.CS_W(CS_W), .VEC_W(VEC_W), .SEG_W(SEG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .cs_i(cs_i),
  .seg_o(seg_o), .ctrl_o(ctrl_o), .scl_s(scl_s), .stop_det(stop_det),
  .byte_done(byte_done), .st(st), .vec(vec), .bit_cnt(bit_cnt)
);

// File: tb/seg_loader_i2c_tb.sv
module seg_loader_i2c_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] cs = 3'd5;
  logic       sda_oe;
  logic [63:0] seg;
  logic [7:0]  ctrl;
  wire         sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_loader_i2c u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .cs_i(cs), .sda_oe_o(sda_oe), .seg_o(seg), .ctrl_o(ctrl)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic  ack_strobe = 1'b0;

  logic [7:0] m_seg [8];
  logic [7:0] m_ctrl;
  logic [5:0] m_vec;
  logic [7:0] pay [8];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected acknowledge at each acknowledge clock
  always @(posedge ack_strobe) begin
    logic  e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(t, {63'd0, sda_oe}, {63'd0, e});
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wclk(QTR);
    scl_m = 1'b1; wclk(2*QTR);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp, input string tag);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    ack_strobe = 1'b1; wclk(QTR);
    ack_strobe = 1'b0;
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b0; wclk(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(QTR);
    scl_m = 1'b1; wclk(QTR);
    sda_m = 1'b1; wclk(2*QTR);
  endtask

  // one transfer; the expectations follow the requirements
  task automatic load(input logic [7:0] adr, input logic [7:0] cb, input int n,
                      input string dtag);
    logic ok, hit;
    bus_start();
    ok = (adr == 8'h74);
    send_byte(adr, ok, "R2");
    if (ok) begin
      send_byte(cb, 1'b1, "R3");
      m_ctrl = cb;
      m_vec  = cb[5:0];
      for (int i = 0; i < n; i++) begin
        hit = (m_vec[5:3] == cs);
        if (hit) m_seg[m_vec[2:0]] = pay[i];
        send_byte(pay[i], hit, dtag);
        m_vec = m_vec + 6'd1;
      end
    end else begin
      send_byte(cb, 1'b0, "R8");
      for (int i = 0; i < n; i++) send_byte(pay[i], 1'b0, "R8");
    end
    bus_stop();
  endtask

  task automatic check_regs(input string tag);
    check(tag, {56'd0, ctrl}, {56'd0, m_ctrl});
    for (int k = 0; k < 8; k++) check(tag, {56'd0, seg[k*8 +: 8]}, {56'd0, m_seg[k]});
    check("R9", {63'd0, sda_oe}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m_seg[k] = 8'h00;
    m_ctrl = 8'h00;
    m_vec  = 6'd0;
    wclk(4);
    check_regs("R1");
    rst_n = 1'b1;
    wclk(4);
    check_regs("R1");

    // R4: vector 40..43 owned by code 5 -> bytes 0..3
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3; pay[3] = 8'hD4;
    load(8'h74, 8'h28, 4, "R4");
    check_regs("R4");

    // R5: vector 46..49, the last two belong to code 6
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
    load(8'h74, 8'h6E, 4, "R5");
    check_regs("R5");

    // R7: stop right after the control byte
    load(8'h74, 8'hC2, 0, "R7");
    check_regs("R7");

    // R6: code 0, vector 62,63 then wrap to 0,1
    cs = 3'd0;
    pay[0] = 8'h5A; pay[1] = 8'hA5; pay[2] = 8'h3C; pay[3] = 8'hC3;
    load(8'h74, 8'h3E, 4, "R6");
    check_regs("R6");

    // R2: read bit and foreign address are ignored
    load(8'h75, 8'h00, 2, "R2");
    check_regs("R2");
    load(8'h76, 8'h01, 1, "R2");
    check_regs("R2");

    // R8: rejected address, then repeated start with the right one
    cs = 3'd2;
    bus_start();
    send_byte(8'h70, 1'b0, "R8");
    send_byte(8'h10, 1'b0, "R8");
    pay[0] = 8'hE7; pay[1] = 8'h7E;
    load(8'h74, 8'h97, 2, "R8");
    check_regs("R8");

    // R3: address and control acknowledged with a non-owning code
    cs = 3'd7;
    pay[0] = 8'h99;
    load(8'h74, 8'h81, 1, "R3");
    check_regs("R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule